// File: doc/BRIEF.md
# Flash Bus Pin Front-End

This block is the pin-facing control logic of an 8-bit parallel NOR-style flash device model. It watches four active-low control pins and a low-supply flag. The pins are chip select, output enable, write enable and a hardware reset. From them it decides which bus mode the device is in. It produces a registered mode code, an enable for the data-bus drivers, a one-cycle latch strobe for the command register, a hold signal for the command logic and a ready/busy indication. The command state machine, the array and all analog sensing sit outside. The neighbouring controller reports a running program or erase through a single `op_active` input.

The block's main job is to keep spurious bus activity from starting a command. A write is accepted only for one exact pin pattern, and the strobe fires when write enable returns high. A lockout taken at power-up rejects a write pattern that is already present when the device wakes. A low-supply flag blocks all writes. When the hardware reset is pulled during an embedded operation, ready stays low for a fixed settle interval. After the reset pin is released, reads stay blocked for a recovery interval.

Top module: `flash_bus_frontend`

## Requirements
- R1: Every pin input passes through a two-stage synchroniser whose flops start at the idle level (control pins high, low-supply flag low), and every output is registered, so a pin change first shows at the outputs after the third rising clock edge. During `rst`, `bus_mode`=0, `dq_oe`=0, `wr_strobe`=0, `ctl_reset`=1 and `ready`=1.
- R2: `bus_mode` codes are 0 standby, 1 read, 2 write, 3 output disable, 4 reset. Reset pin low gives 4. Otherwise chip select high gives 0. With chip select low: write enable low and output enable high gives 2; output enable low and write enable high gives 1; both high gives 3.
- R3: `dq_oe` is 1 only in read mode and only after the recovery interval of R10; it is 0 in standby (even with output enable low), write, output disable and reset modes.
- R4: A write is recognised when chip select and write enable are low and output enable is high. `wr_strobe` pulses when write enable is next seen high, provided chip select is still low and output enable still high.
- R5: `wr_strobe` is never high on two consecutive cycles, and one write enable low phase yields at most one pulse.
- R6: While the reset pin is low, `ctl_reset`=1, `dq_oe`=0 and write attempts produce no strobe.
- R7: While `vcc_low`=1, `ctl_reset`=1 and no write produces a strobe.
- R8: `ready`=0 while `op_active`=1 with the reset pin high. If the reset pin falls while `op_active`=1, `ready` stays 0 for exactly READY_DLY cycles. If it falls with no operation running, `ready` stays 1.
- R9: If the write pattern is present when `rst` releases, no strobe is produced when write enable later rises. Writes are accepted only after a non-write pattern has been seen.
- R10: After the reset pin returns high, `dq_oe` stays 0 for RECOV_CYC cycles in which read mode is shown.
- R11: Output enable and write enable both low with chip select low is treated as output disable: mode 3, no drive and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select pin, active low, asynchronous |
| out_en_n | input | 1 | Output enable pin, active low, asynchronous |
| wr_en_n | input | 1 | Write enable pin, active low, asynchronous |
| hard_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| vcc_low | input | 1 | Low-supply flag, asynchronous |
| op_active | input | 1 | Embedded program/erase running (from controller) |
| bus_mode | output | 3 | Decoded bus mode code |
| dq_oe | output | 1 | Data-bus output driver enable |
| wr_strobe | output | 1 | One-cycle command latch strobe |
| ctl_reset | output | 1 | Hold for the command logic |
| ready | output | 1 | Ready/busy, 0 means busy |

## Verification
A stuck or wrong lockout flag shows at `wr_strobe`. Either a pulse appears three cycles after write enable rises from a power-up write pattern, or no pulse ever appears for a legal write. A wrong busy or recovery counter shows as `ready` or `dq_oe` changing one or more cycles away from the expected edge. The bench's cycle model catches this on the exact cycle. A wrong mode decode shows on `bus_mode` three edges after the pins change, and the per-cycle comparison exposes it at once.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_READ    = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_OUTDIS  = 3'd3,
    MODE_RESET   = 3'd4
  } bus_mode_e;
endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= INIT;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= INIT;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fbf_decode.sv
module fbf_decode
  import fbf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ce_s,
  input  logic      oe_s,
  input  logic      we_s,
  input  logic      rp_s,
  input  logic      recov_busy,
  output bus_mode_e mode_q,
  output logic      dq_oe_q,
  output logic      write_like
);
  bus_mode_e mode_d;

  always_comb begin
    if (!rp_s)              mode_d = MODE_RESET;
    else if (ce_s)          mode_d = MODE_STANDBY;
    else if (!we_s && oe_s) mode_d = MODE_WRITE;
    else if (!oe_s && we_s) mode_d = MODE_READ;
    else                    mode_d = MODE_OUTDIS;
  end

  assign write_like = rp_s && !ce_s && !we_s && oe_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_STANDBY;
      dq_oe_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      dq_oe_q <= (mode_d == MODE_READ) && !recov_busy;
    end
  end
endmodule

// File: rtl/fbf_reset_ctl.sv
module fbf_reset_ctl #(
  parameter int READY_DLY = 20,
  parameter int RECOV_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic rp_s,
  input  logic vl_s,
  input  logic op_active,
  output logic recov_busy,
  output logic ready_q,
  output logic ctl_reset_q
);
  localparam int BW = $clog2(READY_DLY + 1);
  localparam int RW = $clog2(RECOV_CYC + 1);

  logic          rp_d;
  logic [BW-1:0] busy_cnt, busy_n;
  logic [RW-1:0] recov_cnt, recov_n;
  logic          rp_fall;

  assign rp_fall = !rp_s && rp_d;

  always_comb begin
    if (rp_fall && op_active)   busy_n = BW'(READY_DLY);
    else if (busy_cnt != '0)    busy_n = busy_cnt - 1'b1;
    else                        busy_n = '0;
    if (!rp_s)                  recov_n = RW'(RECOV_CYC);
    else if (recov_cnt != '0)   recov_n = recov_cnt - 1'b1;
    else                        recov_n = '0;
  end

  assign recov_busy = (recov_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_d        <= 1'b1;
      busy_cnt    <= '0;
      recov_cnt   <= '0;
      ready_q     <= 1'b1;
      ctl_reset_q <= 1'b1;
    end else begin
      rp_d        <= rp_s;
      busy_cnt    <= busy_n;
      recov_cnt   <= recov_n;
      ready_q     <= (busy_n == '0) && !(rp_s && op_active);
      ctl_reset_q <= !rp_s || vl_s;
    end
  end
endmodule

// File: rtl/fbf_write_gate.sv
module fbf_write_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_s,
  input  logic oe_s,
  input  logic we_s,
  input  logic rp_s,
  input  logic vl_s,
  input  logic write_like,
  output logic strobe_q
);
  localparam int VW = $clog2(SYNC_STAGES + 1);

  logic [VW-1:0] warm_cnt;
  logic          warm;
  logic          lockout;
  logic          armed;
  logic          strobe_d;

  assign warm     = (warm_cnt == VW'(SYNC_STAGES));
  assign strobe_d = armed && we_s && !ce_s && oe_s && rp_s && !vl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_cnt <= '0;
      lockout  <= 1'b1;
      armed    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (!warm) warm_cnt <= warm_cnt + 1'b1;
      if (warm && !write_like) lockout <= 1'b0;
      armed    <= write_like && !lockout && !vl_s;
      strobe_q <= strobe_d;
    end
  end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import fbf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int READY_DLY   = 20,
  parameter int RECOV_CYC   = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chip_sel_n,
  input  logic       out_en_n,
  input  logic       wr_en_n,
  input  logic       hard_rst_n,
  input  logic       vcc_low,
  input  logic       op_active,
  output logic [2:0] bus_mode,
  output logic       dq_oe,
  output logic       wr_strobe,
  output logic       ctl_reset,
  output logic       ready
);
  localparam int NPIN = 5;
  localparam logic [NPIN-1:0] PIN_IDLE = 5'b01111;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic ce_s, oe_s, we_s, rp_s, vl_s;
  logic recov_busy, write_like;
  bus_mode_e mode_q;

  assign pins_raw = {vcc_low, hard_rst_n, wr_en_n, out_en_n, chip_sel_n};
  assign {vl_s, rp_s, we_s, oe_s, ce_s} = pins_s;

  fbf_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  fbf_decode u_decode (
    .clk(clk), .rst(rst), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .rp_s(rp_s),
    .recov_busy(recov_busy), .mode_q(mode_q), .dq_oe_q(dq_oe),
    .write_like(write_like)
  );

  fbf_reset_ctl #(.READY_DLY(READY_DLY), .RECOV_CYC(RECOV_CYC)) u_rstctl (
    .clk(clk), .rst(rst), .rp_s(rp_s), .vl_s(vl_s), .op_active(op_active),
    .recov_busy(recov_busy), .ready_q(ready), .ctl_reset_q(ctl_reset)
  );

  fbf_write_gate #(.SYNC_STAGES(SYNC_STAGES)) u_wgate (
    .clk(clk), .rst(rst), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .rp_s(rp_s),
    .vl_s(vl_s), .write_like(write_like), .strobe_q(wr_strobe)
  );

  assign bus_mode = mode_q;
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker (
  input logic       clk,
  input logic       rst,
  input logic       rp_s,
  input logic       vl_s,
  input logic       op_active,
  input logic [2:0] bus_mode,
  input logic       dq_oe,
  input logic       wr_strobe,
  input logic       ctl_reset,
  input logic       ready
);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  assert_drive_read_only_R3: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (bus_mode == 3'd1));

  assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_mode == 3'd4) |-> (!dq_oe && ctl_reset));

  assert_lowvcc_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    vl_s |=> (!wr_strobe && ctl_reset));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(rp_s) && op_active) |=> !ready);

  assert_pin_reset_holds_ctl_R6: assert property (@(posedge clk) disable iff (rst)
    !rp_s |=> ctl_reset);
endmodule

bind flash_bus_frontend fbf_checker u_chk (
  .clk(clk), .rst(rst), .rp_s(rp_s), .vl_s(vl_s), .op_active(op_active),
  .bus_mode(bus_mode), .dq_oe(dq_oe), .wr_strobe(wr_strobe),
  .ctl_reset(ctl_reset), .ready(ready)
);

// File: tb/flash_bus_frontend_tb.sv
`timescale 1ns/1ps
module flash_bus_frontend_tb;
  localparam int READY_DLY = 20;
  localparam int RECOV_CYC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0, hr_n = 1'b1, vlow = 1'b0, op = 1'b0;
  logic [2:0] bus_mode;
  logic dq_oe, wr_strobe, ctl_reset, ready;

  always #5 clk = ~clk;

  flash_bus_frontend #(.SYNC_STAGES(2), .READY_DLY(READY_DLY), .RECOV_CYC(RECOV_CYC)) u_dut (
    .clk(clk), .rst(rst), .chip_sel_n(ce_n), .out_en_n(oe_n), .wr_en_n(we_n),
    .hard_rst_n(hr_n), .vcc_low(vlow), .op_active(op), .bus_mode(bus_mode),
    .dq_oe(dq_oe), .wr_strobe(wr_strobe), .ctl_reset(ctl_reset), .ready(ready)
  );

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  int cycles = 0;
  bit model_ok = 0;

  // Behavioural reference: queues model the two synchroniser stages.
  bit q_ce[$], q_oe[$], q_we[$], q_hr[$], q_vl[$];
  int e_mode = 0, e_oe = 0, e_stb = 0, e_ctl = 1, e_rdy = 1;
  int busy = 0, recov = 0, warm = 0;
  bit lock = 1, armed = 0, hr_prev = 1;

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic void model_reset();
    q_ce = '{1, 1}; q_oe = '{1, 1}; q_we = '{1, 1}; q_hr = '{1, 1}; q_vl = '{0, 0};
    e_mode = 0; e_oe = 0; e_stb = 0; e_ctl = 1; e_rdy = 1;
    busy = 0; recov = 0; warm = 0; lock = 1; armed = 0; hr_prev = 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (rst) model_reset();
    else begin
      bit c, o, w, r, v, wl;
      c = q_ce[0]; o = q_oe[0]; w = q_we[0]; r = q_hr[0]; v = q_vl[0];
      if (!r) e_mode = 4; else if (c) e_mode = 0;
      else if (!w && o) e_mode = 2; else if (!o && w) e_mode = 1; else e_mode = 3;
      wl = r && !c && !w && o;
      e_stb = (armed && w && !c && o && r && !v) ? 1 : 0;
      e_oe  = (e_mode == 1 && recov == 0) ? 1 : 0;
      armed = wl && !lock && !v;
      if (warm == 2 && !wl) lock = 0;
      if (warm < 2) warm++;
      e_ctl = (!r || v) ? 1 : 0;
      if (!r && hr_prev && op) busy = READY_DLY; else if (busy > 0) busy--;
      e_rdy = (busy == 0 && !(r && op)) ? 1 : 0;
      hr_prev = r;
      if (!r) recov = RECOV_CYC; else if (recov > 0) recov--;
      void'(q_ce.pop_front()); q_ce.push_back(ce_n);
      void'(q_oe.pop_front()); q_oe.push_back(oe_n);
      void'(q_we.pop_front()); q_we.push_back(we_n);
      void'(q_hr.pop_front()); q_hr.push_back(hr_n);
      void'(q_vl.pop_front()); q_vl.push_back(vlow);
    end
    model_ok = 1;
  end

  always @(negedge clk) begin
    if (wr_strobe) strobes++;
    if (model_ok) begin
      check_eq("R2 bus_mode", bus_mode, e_mode);
      check_eq("R3 dq_oe", dq_oe, e_oe);
      check_eq("R4 wr_strobe", wr_strobe, e_stb);
      check_eq("R6 ctl_reset", ctl_reset, e_ctl);
      check_eq("R8 ready", ready, e_rdy);
    end
  end

  task automatic pins(bit c, bit o, bit w);
    ce_n = c; oe_n = o; we_n = w;
  endtask

  initial begin
    int base, cnt;
    // R1 reset state, with write pattern held through reset (R9)
    wait_cyc(5);
    check_eq("R1 reset mode", bus_mode, 0);
    check_eq("R1 reset dq_oe", dq_oe, 0);
    check_eq("R1 reset ctl_reset", ctl_reset, 1);
    check_eq("R1 reset ready", ready, 1);
    rst = 1'b0;
    wait_cyc(10);
    we_n = 1'b1;
    wait_cyc(6);
    check_eq("R9 no strobe after power-up write pattern", strobes, 0);

    // R2/R3 read
    pins(0, 0, 1); wait_cyc(6);
    check_eq("R2 read mode", bus_mode, 1);
    check_eq("R3 read drives", dq_oe, 1);

    // R4/R5 three legal writes
    base = strobes;
    for (int k = 0; k < 3; k++) begin
      pins(0, 1, 0); wait_cyc(4);
      check_eq("R2 write mode", bus_mode, 2);
      pins(0, 1, 1); wait_cyc(4);
    end
    check_eq("R4 three strobes", strobes - base, 3);
    pins(0, 1, 0); wait_cyc(12);
    pins(0, 1, 1); wait_cyc(12);
    check_eq("R5 long low phase one strobe", strobes - base, 4);

    // R3 standby ignores output enable
    pins(1, 0, 1); wait_cyc(5);
    check_eq("R3 standby no drive", dq_oe, 0);
    check_eq("R2 standby mode", bus_mode, 0);

    // R11 both enables low
    base = strobes;
    pins(0, 0, 0); wait_cyc(5);
    check_eq("R11 mode outdis", bus_mode, 3);
    check_eq("R11 no drive", dq_oe, 0);
    pins(0, 0, 1); wait_cyc(5);
    check_eq("R11 no strobe", strobes - base, 0);

    // R7 low supply
    vlow = 1'b1; wait_cyc(4);
    base = strobes;
    pins(0, 1, 0); wait_cyc(4); pins(0, 1, 1); wait_cyc(5);
    check_eq("R7 no strobe under low supply", strobes - base, 0);
    check_eq("R7 ctl_reset held", ctl_reset, 1);
    vlow = 1'b0; pins(1, 1, 1); wait_cyc(5);
    check_eq("R7 ctl_reset released", ctl_reset, 0);

    // R8 busy while op, reset during op
    op = 1'b1; wait_cyc(4);
    check_eq("R8 busy during op", ready, 0);
    hr_n = 1'b0; wait_cyc(3);
    op = 1'b0;
    wait_cyc(READY_DLY / 2);
    check_eq("R8 busy held after reset", ready, 0);
    check_eq("R6 reset mode", bus_mode, 4);
    base = strobes;
    pins(0, 1, 0); wait_cyc(4); pins(0, 1, 1); wait_cyc(4);
    check_eq("R6 no strobe in reset", strobes - base, 0);
    wait_cyc(READY_DLY);
    check_eq("R8 ready after delay", ready, 1);

    // R10 recovery
    pins(0, 0, 1); hr_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_mode == 1 && dq_oe == 0) cnt++;
    end
    check_eq("R10 recovery cycles", cnt, RECOV_CYC);
    check_eq("R10 drives after recovery", dq_oe, 1);

    // R8 reset with no op keeps ready high
    cnt = 0;
    hr_n = 1'b0;
    for (int i = 0; i < READY_DLY + 6; i++) begin
      @(negedge clk);
      if (!ready) cnt++;
    end
    check_eq("R8 idle reset stays ready", cnt, 0);
    hr_n = 1'b1; wait_cyc(10);

    finish_run();
  end
endmodule